// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block provides two independent down-counting interval timers for a sound generator, together with their control byte and an 8-bit status byte. Software writes an address and a data byte on a single write port. The block counts master-clock cycles through a one-cycle enable strobe. It presents the status byte on a read port that has no side effects.

Timer A is a 10-bit counter that is updated once per 144 master cycles. Timer B is an 8-bit counter that is updated on every sixteenth timer A slot. On an update, a timer decrements if its count is nonzero. If the count is zero, the timer reloads from its programmed value and may raise a sticky flag. Every data write also raises a busy bit for a fixed number of master cycles.

Top module: `interval_timer_unit`

## Requirements
- R1: Reset clears both counters, all load values, the control bits, both flags and the busy bit, so `status_o` reads 0x00.
- R2: The timer A reload value is {data of the last write to address 0x24, bits 1:0 of the last write to address 0x25}. The upper six bits of a write to 0x25 are ignored.
- R3: The timer B reload value is the data of the last write to address 0x26.
- R4: Address 0x27 holds the control bits. Bit 0 lets timer A run, bit 1 lets timer B run, bit 2 allows the timer A flag and bit 3 allows the timer B flag.
- R5: Timer A update slots occur on the first master cycle after reset and then every 144 master cycles. A running timer A decrements when nonzero and reloads when zero, so with reload value L it expires once every 144*(L+1) master cycles. The first slot after reset expires it at once.
- R6: Timer B is updated only on every sixteenth timer A slot, starting with the first slot. It is updated only while both control bit 0 and control bit 1 are set. It follows the same decrement and reload rule, so its expiry period is 2304*(L+1) master cycles.
- R7: On expiry with its flag allowed, timer A sets status bit 0 and timer B sets status bit 1. A flag stays set until it is cleared. When the flag is not allowed, expiry leaves the status unchanged.
- R8: A write to 0x27 with data bit 4 set clears status bit 0, and with data bit 5 set clears status bit 1. Bits 4 and 5 are not stored. If an expiry and a clear land on the same clock, the flag is set.
- R9: Any data write sets status bit 7 (busy). The bit clears on the 17th master-cycle strobe after the write's clock and does not count down while the strobe is low.
- R10: Writes to addresses other than 0x24 to 0x27 change only the busy bit. Status bits 6 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_en_i | input | 1 | One master cycle elapses on each clock where this is high |
| wr_en_i | input | 1 | Data write strobe |
| wr_addr_i | input | 8 | Register address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| status_o | output | 8 | Status byte: bit 7 busy, bit 1 flag B, bit 0 flag A |

## Verification
A counter that has been corrupted or loaded wrongly only becomes visible when a flag is raised: the flag appears either earlier or later than the predicted slot, by at least one 144-cycle slot for timer A or one 2304-cycle slot for timer B. Because of this, every check on a flag is placed on the exact master cycle where it should rise, and on the cycle just before it. A wrong sub-divider phase or a missing run gate for timer B shows up as a flag set during a window in which none is expected. A fault in the busy counter is visible within 17 master cycles of a write.

// File: rtl/itu_pkg.sv
`timescale 1ns/1ps
package itu_pkg;
  localparam logic [7:0] ADDR_TA_HI = 8'h24;
  localparam logic [7:0] ADDR_TA_LO = 8'h25;
  localparam logic [7:0] ADDR_TB    = 8'h26;
  localparam logic [7:0] ADDR_CTRL  = 8'h27;

  localparam int CTRL_CLR_A = 4;
  localparam int CTRL_CLR_B = 5;

  typedef struct packed {
    logic flg_b;
    logic flg_a;
    logic run_b;
    logic run_a;
  } ctrl_t;
endpackage

// File: rtl/itu_prescaler.sv
`timescale 1ns/1ps
module itu_prescaler #(
  parameter int unsigned PRE_A = 144,
  parameter int unsigned B_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  output logic tick_a_o,
  output logic tick_b_o
);
  localparam int unsigned PW = (PRE_A > 1) ? $clog2(PRE_A) : 1;
  localparam int unsigned BW = (B_DIV > 1) ? $clog2(B_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_A - 1);
  localparam logic [BW-1:0] DIV_LAST = BW'(B_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [BW-1:0] sub_q;

  assign tick_a_o = cyc_en_i && (pre_q == '0);
  assign tick_b_o = tick_a_o && (sub_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      if (cyc_en_i) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (tick_a_o) sub_q <= (sub_q == DIV_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  a_r5_pre_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST);
  a_r6_sub_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= DIV_LAST);
  generate
    if (PRE_A > 1) begin : g_gap
      a_r5_slot_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_a_o |=> !tick_a_o);
    end
  endgenerate
endmodule

// File: rtl/itu_timer.sv
`timescale 1ns/1ps
module itu_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] load_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = upd_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (upd_i) cnt_q <= (cnt_q == '0) ? load_i : cnt_q - 1'b1;
  end

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && cnt_q == '0) |=> cnt_q == $past(load_i));
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cnt_q));
endmodule

// File: rtl/itu_busy.sv
`timescale 1ns/1ps
module itu_busy #(
  parameter int unsigned HOLD = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic cyc_en_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (wr_i)                    cnt_q <= HOLD_V;
    else if (cyc_en_i && busy_o)      cnt_q <= cnt_q - 1'b1;
  end

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> busy_o);
  a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD_V);
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !cyc_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/interval_timer_unit.sv
`timescale 1ns/1ps
module interval_timer_unit
  import itu_pkg::*;
#(
  parameter int unsigned TA_W      = 10,
  parameter int unsigned TB_W      = 8,
  parameter int unsigned TA_PERIOD = 144,
  parameter int unsigned TB_DIV    = 16,
  parameter int unsigned BUSY_HOLD = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] status_o
);
  localparam int unsigned LO_W = TA_W - 8;

  logic [7:0]      ta_hi_q;
  logic [LO_W-1:0] ta_lo_q;
  logic [TB_W-1:0] tb_load_q;
  ctrl_t           ctrl_q;
  logic            flag_a_q, flag_b_q;

  logic tick_a, tick_b, upd_a, upd_b, exp_a, exp_b, busy;
  logic sel_hi, sel_lo, sel_tb, sel_ctrl, clr_a, clr_b;

  assign sel_hi   = wr_en_i && (wr_addr_i == ADDR_TA_HI);
  assign sel_lo   = wr_en_i && (wr_addr_i == ADDR_TA_LO);
  assign sel_tb   = wr_en_i && (wr_addr_i == ADDR_TB);
  assign sel_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_a    = sel_ctrl && wr_data_i[CTRL_CLR_A];
  assign clr_b    = sel_ctrl && wr_data_i[CTRL_CLR_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ta_hi_q   <= '0;
      ta_lo_q   <= '0;
      tb_load_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (sel_hi)   ta_hi_q   <= wr_data_i;
      if (sel_lo)   ta_lo_q   <= wr_data_i[LO_W-1:0];
      if (sel_tb)   tb_load_q <= wr_data_i[TB_W-1:0];
      if (sel_ctrl) ctrl_q    <= ctrl_t'(wr_data_i[3:0]);
    end
  end

  itu_prescaler #(.PRE_A(TA_PERIOD), .B_DIV(TB_DIV)) u_pre (
    .clk_i, .rst_ni, .cyc_en_i,
    .tick_a_o(tick_a), .tick_b_o(tick_b)
  );

  // timer B sits inside timer A's gated update step
  assign upd_a = tick_a && ctrl_q.run_a;
  assign upd_b = tick_b && ctrl_q.run_a && ctrl_q.run_b;

  itu_timer #(.W(TA_W)) u_ta (
    .clk_i, .rst_ni, .upd_i(upd_a), .load_i({ta_hi_q, ta_lo_q}), .expire_o(exp_a)
  );

  itu_timer #(.W(TB_W)) u_tb (
    .clk_i, .rst_ni, .upd_i(upd_b), .load_i(tb_load_q), .expire_o(exp_b)
  );

  itu_busy #(.HOLD(BUSY_HOLD)) u_busy (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .cyc_en_i, .busy_o(busy)
  );

  // set beats clear on a coinciding clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
    end else begin
      if (exp_a && ctrl_q.flg_a) flag_a_q <= 1'b1;
      else if (clr_a)            flag_a_q <= 1'b0;
      if (exp_b && ctrl_q.flg_b) flag_b_q <= 1'b1;
      else if (clr_b)            flag_b_q <= 1'b0;
    end
  end

  assign status_o = {busy, 5'b0, flag_b_q, flag_a_q};

  a_r7_sticky_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_a_q && !sel_ctrl) |=> flag_a_q);
  a_r7_sticky_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_b_q && !sel_ctrl) |=> flag_b_q);
  a_r7_gate_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.flg_a && !flag_a_q) |=> !flag_a_q);
  a_r6_gate_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run_a && !flag_b_q) |=> !flag_b_q);
  a_r10_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(sel_hi || sel_lo || sel_tb || sel_ctrl)) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_interval_timer_unit.sv
`timescale 1ns/1ps
module tb_interval_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];
  event  sb_ev;

  always #10 clk = ~clk;

  interval_timer_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .status_o(status)
  );

  // master-cycle count seen by the bench
  always @(posedge clk) begin
    if (!rst_n)      ncyc <= 0;
    else if (cyc_en) ncyc <= ncyc + 1;
  end

  // monitor
  initial begin
    item_t it;
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (status !== it.exp) begin
          n_bad++;
          $display("FAIL %s at cycle %0d: status=%02h expected %02h",
                   it.req, ncyc, status, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] exp, input string req);
    item_t it;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h00, "R1 reset state");

    // R2/R4 program timer A reload 1, run + flag, with master cycles stopped
    wr(8'h24, 8'h00);
    wr(8'h25, 8'hFD);
    wr(8'h27, 8'h05);
    chk(8'h80, "R9 busy after write, R5 no slot without strobe");
    repeat (5) @(negedge clk);
    chk(8'h80, "R9 busy frozen while strobe low");

    cyc_en = 1'b1;
    wait_cyc(1);   chk(8'h81, "R5 first slot expires zeroed counter, R7 flag");
    wait_cyc(16);  chk(8'h81, "R9 busy before 17th strobe");
    wait_cyc(17);  chk(8'h01, "R9 busy cleared at 17th strobe");
    wait_cyc(20);  wr(8'h27, 8'h15);
    chk(8'h80, "R8 clear flag A");
    wait_cyc(37);  chk(8'h80, "R9 busy held after mid-run write");
    wait_cyc(38);  chk(8'h00, "R9 busy released");
    wait_cyc(288); chk(8'h00, "R5 no expiry before 2 slots");
    wait_cyc(289); chk(8'h01, "R5 expiry period 144*(L+1)");

    // timer B reload 1, enable all, clear both
    wait_cyc(300);  wr(8'h26, 8'h01);
    wait_cyc(310);  wr(8'h27, 8'h3F);
    chk(8'h80, "R8 clear both flags");
    wait_cyc(2304); chk(8'h01, "R6 B before 16th slot");
    wait_cyc(2305); chk(8'h03, "R6 B expiry on 16th slot, R3");
    wait_cyc(2400); wr(8'h27, 8'h2F);
    chk(8'h81, "R8 clear flag B only");
    wait_cyc(6912); chk(8'h01, "R3 B period before expiry");
    wait_cyc(6913); chk(8'h03, "R3 B period 2304*(L+1)");

    // B gated by A run bit
    wait_cyc(7000);  wr(8'h27, 8'h3E);
    chk(8'h80, "R4 A stopped, flags cleared");
    wait_cyc(11530); chk(8'h00, "R6 B frozen while A stopped");

    // flags disallowed
    wait_cyc(11600); wr(8'h27, 8'h03);
    wait_cyc(16200); chk(8'h00, "R7 no flag when not allowed");

    // reset mid-run and check split reload value
    rst_n = 1'b0;
    cyc_en = 1'b0;
    @(negedge clk);
    chk(8'h00, "R1 reset clears state");
    rst_n = 1'b1;
    @(negedge clk);
    wr(8'h24, 8'h01);
    wr(8'h25, 8'hFE);
    wr(8'h27, 8'h05);
    wr(8'h22, 8'hFF);
    wr(8'h2A, 8'h3F);
    chk(8'h80, "R10 other addresses set only busy");
    cyc_en = 1'b1;
    wait_cyc(1);    chk(8'h81, "R1 counter zero after reset");
    wait_cyc(30);   wr(8'h27, 8'h15);
    wait_cyc(1008); chk(8'h00, "R2 no expiry before 7 slots");
    wait_cyc(1009); chk(8'h01, "R2 reload {0x24,0x25[1:0]}=6");

    done = 1'b1;
    #1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule